// File: doc/BRIEF.md
# Host Responder for Device-Ended Ultra DMA Write Bursts

This block is the host side of an Ultra DMA data-out burst. Its job is to follow the device through a termination that the device starts. While a burst is open, the block sends words from a local source. Each accepted word toggles the host strobe and drives the word onto the 16-bit data bus. When the device deasserts its ready line, the block keeps a short grace window of `T_RFS` cycles. During that window a pending word may still go out, and only while the device request is still high. After the window closes, no more strobe edges are made, and the running CRC value supplied at an input is put on the bus.

When the device then drops its DMA request, the block raises STOP. In the same cycle it forces the host strobe high; this edge carries no data. The block then holds DMA acknowledge (active low) asserted until two separate minimum delays have both passed. One is counted from the moment the control lines settle (`T_MLI`). The other is counted from the moment the CRC appears on the bus (`T_DVS`). Acknowledge is then released, and a one-cycle completion pulse is given.

The two device lines pass through two-flop synchronizers. Every timing limit is a parameter counted in clock cycles.

Top module: `udma_term_host`

## Requirements
- R1: While reset is asserted: `dmack_n`=1, `stop`=0, `hstrobe`=1, `done`=0, `dd`=0, `wr_take`=0.
- R2: In the idle state, a high `start` makes `dmack_n` go low at the next edge. While the burst is open, `wr_take` is high in any cycle where `wr_valid` is high and the synchronized ready is asserted (`dev_rdy_n`=0). At the edge that ends such a cycle, `hstrobe` toggles and `dd` takes `wr_data`.
- R3: `dev_rdy_n` and `dev_dmarq` reach the control logic only after two clock edges of synchronization. A change on a pin is first acted on in the cycle after the second edge.
- R4: The synchronized ready can be seen deasserted during a burst. For the next `T_RFS` cycles a word with `wr_valid` high may still be taken, but only while the synchronized request is high. After that window, `hstrobe` makes no edge other than the single rise of R6.
- R5: The CRC input is copied onto `dd` in two cases: at the edge that closes the grace window, or at the edge where a low request ends that window early. Later changes of `crc_val` have no effect on `dd`.
- R6: The synchronized request can be seen low once the ready has been seen deasserted. At the next edge, `stop` goes high and `hstrobe` is forced high. This is within `T_LI` cycles, and no word is transferred.
- R7: Once raised, `stop` and `hstrobe` both stay high until `dmack_n` returns high.
- R8: `dmack_n` goes high at the first edge at which two counts are both complete. One is at least `T_MLI` cycles with `stop` high. The other is at least `T_DVS` cycles with the CRC on `dd`. So acknowledge is released `max(T_MLI+1, T_DVS+1 - cycles already elapsed)` edges after `stop` rises.
- R9: `done` is high for exactly one cycle, starting at the edge where `dmack_n` rises. At that same edge `stop` returns low.
- R10: A low request while the ready is still asserted is ignored. `stop` stays low and the burst continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Open a burst (taken in idle only) |
| wr_valid | input | 1 | A data word is pending at the source |
| wr_data | input | DW | Pending data word |
| wr_take | output | 1 | Word is accepted at the coming edge |
| crc_val | input | DW | Host CRC result to send at burst end |
| dev_rdy_n | input | 1 | Device ready, active low (asynchronous) |
| dev_dmarq | input | 1 | Device DMA request, active high (asynchronous) |
| hstrobe | output | 1 | Host data strobe |
| stop | output | 1 | Host STOP line |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dd | output | DW | Data bus |
| done | output | 1 | One-cycle pulse when the burst is closed |

## Verification
Results arrive at three different delays after their stimulus. A device pin change reaches the control path two edges after it is driven, and the state reacts at the third edge. `wr_take` is combinational and is valid in the same cycle as its inputs. `hstrobe`, `dd`, `stop`, `dmack_n` and `done` change at the edge after the cycle that decided them. The bench drives inputs and samples outputs only on falling edges. Its behavioural model steps once on each rising edge, using the input values that have been held since the previous falling edge. The outputs are then compared half a cycle later, so every result is read in the cycle it becomes due. The directed acknowledge-delay checks count falling-edge samples from the first cycle in which `stop` is seen high.

// File: rtl/udma_term_pkg.sv
package udma_term_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_DRAIN,
    ST_PARK,
    ST_FINISH
  } term_st_e;

  // word acceptance: normal transfer or grace window after ready drop
  function automatic logic window_open(input term_st_e st, input logic valid,
                                       input logic rdy_n_s, input logic rq_s,
                                       input logic win_full);
    logic ok;
    unique case (st)
      ST_XFER:  ok = valid & ~rdy_n_s;
      ST_DRAIN: ok = valid & rq_s & ~win_full;
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  // both minimum delays satisfied while finishing
  function automatic logic release_ok(input term_st_e st, input logic mli_full,
                                      input logic dvs_full);
    return (st == ST_FINISH) & mli_full & dvs_full;
  endfunction

  function automatic logic crc_goes_out(input term_st_e cur, input term_st_e nxt);
    return (cur == ST_DRAIN) & ((nxt == ST_PARK) | (nxt == ST_FINISH));
  endfunction

endpackage

// File: rtl/uterm_sync2.sv
module uterm_sync2 #(
  parameter int unsigned    W       = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {2{RST_VAL[b]}};
      else        sh <= {sh[0], d[b]};
    end
    assign q[b] = sh[1];
  end
endmodule

// File: rtl/uterm_satcnt.sv
module uterm_satcnt #(
  parameter int unsigned  LIMIT = 4,
  localparam int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic full
);
  logic [CW-1:0] cnt;

  assign full = (cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (en && !full)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/udma_term_host.sv
module udma_term_host
  import udma_term_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned T_RFS = 3,
  parameter int unsigned T_LI  = 4,
  parameter int unsigned T_MLI = 5,
  parameter int unsigned T_DVS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_take,
  input  logic [DW-1:0] crc_val,
  input  logic          dev_rdy_n,
  input  logic          dev_dmarq,
  output logic          hstrobe,
  output logic          stop,
  output logic          dmack_n,
  output logic [DW-1:0] dd,
  output logic          done
);

  // synchronized device lines: bit0 ready_n (idles high), bit1 request (idles low)
  logic [1:0] pins_s;
  logic       rdy_n_s;
  logic       rq_s;

  uterm_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dev_dmarq, dev_rdy_n}),
    .q     (pins_s)
  );
  assign rdy_n_s = pins_s[0];
  assign rq_s    = pins_s[1];

  term_st_e st_q, st_d;

  // named internal events
  logic in_drain, in_park, in_finish;
  logic send_w, crc_place_w, release_w, enter_fin_w;
  logic win_full, dvs_full, mli_full;

  assign in_drain  = (st_q == ST_DRAIN);
  assign in_park   = (st_q == ST_PARK);
  assign in_finish = (st_q == ST_FINISH);

  uterm_satcnt #(.LIMIT(T_RFS)) u_win (
    .clk (clk), .rst_n (rst_n),
    .clr (!in_drain), .en (in_drain),
    .full(win_full)
  );

  uterm_satcnt #(.LIMIT(T_DVS)) u_dvs (
    .clk (clk), .rst_n (rst_n),
    .clr (!(in_park || in_finish)), .en (in_park || in_finish),
    .full(dvs_full)
  );

  uterm_satcnt #(.LIMIT(T_MLI)) u_mli (
    .clk (clk), .rst_n (rst_n),
    .clr (!in_finish), .en (in_finish),
    .full(mli_full)
  );

  assign send_w      = window_open(st_q, wr_valid, rdy_n_s, rq_s, win_full);
  assign release_w   = release_ok(st_q, mli_full, dvs_full);
  assign crc_place_w = crc_goes_out(st_q, st_d);
  assign enter_fin_w = (st_d == ST_FINISH) && !in_finish;
  assign wr_take     = send_w;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start)      st_d = ST_XFER;
      ST_XFER:   if (rdy_n_s)    st_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!rq_s)               st_d = ST_FINISH;
        else if (win_full)       st_d = ST_PARK;
      end
      ST_PARK:   if (!rq_s)      st_d = ST_FINISH;
      ST_FINISH: if (release_w)  st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      hstrobe <= 1'b1;
      stop    <= 1'b0;
      dmack_n <= 1'b1;
      dd      <= '0;
      done    <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= release_w;

      if (send_w)           hstrobe <= ~hstrobe;
      else if (enter_fin_w) hstrobe <= 1'b1;

      if (enter_fin_w)      stop <= 1'b1;
      else if (release_w)   stop <= 1'b0;

      if ((st_q == ST_IDLE) && start) dmack_n <= 1'b0;
      else if (release_w)             dmack_n <= 1'b1;

      if (send_w)           dd <= wr_data;
      else if (crc_place_w) dd <= crc_val;
    end
  end

endmodule

// File: rtl/udma_term_host_chk.sv
module udma_term_host_chk #(
  parameter int unsigned T_LI  = 4,
  parameter int unsigned T_MLI = 5,
  parameter int unsigned T_DVS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic rq_s,
  input logic in_drain,
  input logic in_park,
  input logic in_finish,
  input logic crc_place_w,
  input logic release_w,
  input logic wr_take,
  input logic hstrobe,
  input logic stop,
  input logic dmack_n,
  input logic done
);
  int unsigned stop_age;
  int unsigned crc_age;
  int unsigned li_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_age <= 0;
      crc_age  <= 0;
      li_wait  <= 0;
    end else begin
      if (!stop)                 stop_age <= 0;
      else if (stop_age < 1000)  stop_age <= stop_age + 1;

      if (crc_place_w)                                   crc_age <= 0;
      else if ((in_park || in_finish) && crc_age < 1000) crc_age <= crc_age + 1;

      if ((in_drain || in_park) && !rq_s) li_wait <= li_wait + 1;
      else                                li_wait <= 0;
    end
  end

  // R4
  park_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_park && rq_s) |=> $stable(hstrobe));

  // R6
  stop_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    li_wait <= T_LI);

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !release_w) |=> stop);

  // R7
  strobe_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_finish |=> hstrobe);

  // R8
  mli_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |-> (stop_age >= T_MLI));

  // R8
  dvs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |-> (crc_age >= T_DVS));

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dmack_n) |-> ($past(stop) && $past(hstrobe)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  no_take_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !stop);

endmodule

bind udma_term_host udma_term_host_chk #(
  .T_LI (T_LI),
  .T_MLI(T_MLI),
  .T_DVS(T_DVS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rq_s       (rq_s),
  .in_drain   (in_drain),
  .in_park    (in_park),
  .in_finish  (in_finish),
  .crc_place_w(crc_place_w),
  .release_w  (release_w),
  .wr_take    (wr_take),
  .hstrobe    (hstrobe),
  .stop       (stop),
  .dmack_n    (dmack_n),
  .done       (done)
);

// File: tb/test_udma_term_host.sv
module test_udma_term_host;
  localparam int DW    = 16;
  localparam int T_RFS = 3;
  localparam int T_LI  = 4;
  localparam int T_MLI = 5;
  localparam int T_DVS = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          wr_valid;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] crc_val;
  logic          dev_rdy_n;
  logic          dev_dmarq;
  logic          wr_take, hstrobe, stop, dmack_n, done;
  logic [DW-1:0] dd;

  always #10 clk = ~clk;

  udma_term_host #(.DW(DW), .T_RFS(T_RFS), .T_LI(T_LI), .T_MLI(T_MLI), .T_DVS(T_DVS))
  i_udma_term_host (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_take(wr_take), .crc_val(crc_val), .dev_rdy_n(dev_rdy_n), .dev_dmarq(dev_dmarq),
    .hstrobe(hstrobe), .stop(stop), .dmack_n(dmack_n), .dd(dd), .done(done)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // behavioural reference: 0 idle, 1 sending, 2 grace window, 3 parked, 4 finishing
  int            m_state;
  logic          m_hs, m_stop, m_ack_n, m_done;
  logic [DW-1:0] m_dd;
  int            m_win, m_dvs, m_mli;
  logic          r1, r2, q1, q2;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_take();
    if (m_state == 1) return wr_valid && !r2;
    if (m_state == 2) return wr_valid && q2 && (m_win < T_RFS);
    return 1'b0;
  endfunction

  function automatic int inc_sat(input int v, input int lim);
    return (v < lim) ? v + 1 : lim;
  endfunction

  task automatic model_reset();
    m_state = 0; m_hs = 1; m_stop = 0; m_ack_n = 1; m_done = 0; m_dd = '0;
    m_win = 0; m_dvs = 0; m_mli = 0;
    r1 = 1; r2 = 1; q1 = 0; q2 = 0;
  endtask

  task automatic model_step(output logic took);
    logic go;
    go     = exp_take();
    took   = go;
    m_done = 0;
    case (m_state)
      0: if (start) begin m_state = 1; m_ack_n = 0; m_stop = 0; end
      1: begin
        if (go) begin m_hs = !m_hs; m_dd = wr_data; end
        else if (r2) begin m_state = 2; m_win = 0; end
      end
      2: begin
        if (go) begin m_hs = !m_hs; m_dd = wr_data; end
        if (!q2) begin
          m_state = 4; m_stop = 1; m_hs = 1; m_dd = crc_val; m_dvs = 0; m_mli = 0;
        end else if (m_win == T_RFS) begin
          m_state = 3; m_dd = crc_val; m_dvs = 0;
        end else m_win++;
      end
      3: begin
        if (!q2) begin m_state = 4; m_stop = 1; m_hs = 1; m_mli = 0; end
        m_dvs = inc_sat(m_dvs, T_DVS);
      end
      4: begin
        if (m_mli >= T_MLI && m_dvs >= T_DVS) begin
          m_state = 0; m_ack_n = 1; m_stop = 0; m_done = 1;
        end else begin
          m_mli = inc_sat(m_mli, T_MLI);
          m_dvs = inc_sat(m_dvs, T_DVS);
        end
      end
      default: m_state = 0;
    endcase
    r2 = r1; r1 = dev_rdy_n;
    q2 = q1; q1 = dev_dmarq;
  endtask

  task automatic compare_all();
    chk("R2 wr_take", wr_take, exp_take());
    chk("R4 hstrobe", hstrobe, m_hs);
    chk("R5 dd", dd, m_dd);
    chk("R6 stop", stop, m_stop);
    chk("R8 dmack_n", dmack_n, m_ack_n);
    chk("R9 done", done, m_done);
  endtask

  // one cycle: model steps on the rising edge, outputs compared on the falling edge
  task automatic tick();
    logic took;
    @(posedge clk);
    model_step(took);
    @(negedge clk);
    compare_all();
    if (took) wr_data = wr_data + 16'h0001;
  endtask

  // waits for acknowledge release; returns samples counted from first stop-high sample
  task automatic wait_done(output int since);
    since = -1;
    for (int k = 0; k < 80; k++) begin
      tick();
      if (since >= 0) since++;
      else if (stop === 1'b1) since = 0;
      if (stop === 1'b1) chk("R7 stop/hstrobe held", {stop, hstrobe}, 2'b11);
      if (dmack_n === 1'b1) break;
    end
    chk("R9 done with release", done, 1'b1);
    tick();
    chk("R9 done one cycle", done, 1'b0);
  endtask

  task automatic open_burst();
    dev_dmarq = 1; dev_rdy_n = 0;
    repeat (3) tick();
    start = 1;
    tick();
    chk("R2 dmack_n low after start", dmack_n, 1'b0);
    start = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int gap;
    rst_n = 0; start = 0; wr_valid = 0; wr_data = 16'h1000; crc_val = 16'hC0DE;
    dev_rdy_n = 1; dev_dmarq = 0;
    repeat (3) @(negedge clk);
    chk("R1 dmack_n", dmack_n, 1'b1);
    chk("R1 stop", stop, 1'b0);
    chk("R1 hstrobe", hstrobe, 1'b1);
    chk("R1 done", done, 1'b0);
    chk("R1 dd", dd, 16'h0000);
    chk("R1 wr_take", wr_take, 1'b0);
    model_reset();
    rst_n = 1;

    // burst A: steady words, grace window used, CRC change while parked
    open_burst();
    wr_valid = 1;
    repeat (6) tick();
    dev_rdy_n = 1;
    tick();
    chk("R3 ready drop not yet seen", wr_take, 1'b1);
    tick();
    chk("R3 ready drop seen after two edges", wr_take, 1'b0);
    repeat (8) tick();
    wr_valid = 0;
    crc_val = 16'hBEEF;
    repeat (4) tick();
    chk("R5 crc latched", dd, 16'hC0DE);
    dev_dmarq = 0;
    wait_done(gap);

    // burst B: ready and request drop together, CRC delay dominates
    crc_val = 16'h5A5A;
    open_burst();
    for (int k = 0; k < 8; k++) begin
      wr_valid = k[0];
      tick();
    end
    dev_rdy_n = 1; dev_dmarq = 0;
    wait_done(gap);
    chk("R8 release gap (crc bound)", gap, T_DVS + 1);

    // burst C: request low while ready still asserted is ignored
    crc_val = 16'h1234;
    open_burst();
    wr_valid = 1;
    repeat (3) tick();
    dev_dmarq = 0;
    repeat (5) tick();
    chk("R10 stop stays low", stop, 1'b0);
    chk("R10 burst still open", dmack_n, 1'b0);
    dev_rdy_n = 1;
    wait_done(gap);
    wr_valid = 0;

    // burst D: long park, control delay dominates
    crc_val = 16'h0F0F;
    open_burst();
    wr_valid = 1;
    repeat (4) tick();
    wr_valid = 0;
    dev_rdy_n = 1;
    repeat (20) tick();
    chk("R4 no strobe while parked", hstrobe, m_hs);
    dev_dmarq = 0;
    wait_done(gap);
    chk("R8 release gap (control bound)", gap, T_MLI + 1);

    repeat (3) tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule